// File: doc/BRIEF.md
# Pin Interrupt Detector for a GPIO Port

This block is the interrupt side of an eight-pin general purpose I/O port. It receives the synchronized level of each pin and that pin's direction bit. For each pin, configuration decides whether the pin raises a request on a level or on a transition. Every detection is latched into a sticky raw status bit. The raw bits, gated by an enable mask, drive one interrupt line toward the system interrupt controller.

Software uses a small word-addressed register port. It writes the configuration and reads it back, and it reads both the raw and the masked status. It acknowledges events by writing ones to a clear location. Capturing pin data and driving outputs belong to neighbouring logic and are not part of this block.

Register selects on `bus_addr`: 0 sense select (1 = level, 0 = edge), 1 any-edge override, 2 polarity, 3 enable mask, 4 raw status (read only), 5 masked status (read only), 6 clear (write only, reads 0), 7 unused (reads 0, writes ignored).

Top module: `gpio_irq_unit`

## Requirements
- R1: After a synchronous reset, every register (sense, any-edge, polarity, mask, raw status) reads 0 and `irq` is low.
- R2: A pin whose sense bit is 1 sets its raw bit at each clock where its level equals its polarity bit. This holds whatever the pin's direction, and the bit is set again after a clear for as long as the level lasts.
- R3: A pin in edge mode (sense 0) with its any-edge bit at 1 sets its raw bit on either a rise or a fall.
- R4: A pin in edge mode with any-edge 0 sets its raw bit on a rise when its polarity bit is 1, and on a fall when it is 0. The opposite transition has no effect on raw status.
- R5: A pin whose direction bit is 1 (output) never sets its raw bit through edge detection.
- R6: Raw bits stay set until cleared. A write to select 6 clears each raw bit written as 1 and leaves the bits written as 0 unchanged.
- R7: When a clear and a detection hit the same raw bit in the same cycle, the bit stays set.
- R8: Select 5 reads raw status AND mask. `irq` is high exactly when that value is non-zero.
- R9: Selects 0 to 3 read back the last value written. Writes to selects 4, 5 and 7 change nothing, and selects 6 and 7 read 0.
- R10: Detection is registered. A pin change presented before a clock edge appears in raw status and on `irq` right after that edge, and configuration written at an edge governs detection from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write data, one bit per pin |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| pin_lvl | input | 8 | Synchronized pin levels |
| pin_dir | input | 8 | Per-pin direction, 1 = output |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets a clear that lands in the same cycle as a new detection. A design that lets the clear win would lose that event, and raw status would read 0 where 1 is due. It checks that a level-mode pin sets its bit again right after a clear, which a design that treats level as a one-shot edge would miss. It checks that output pins ignore transitions, where a faulty design would raise spurious bits when a pin is driven. It also checks that a single-edge pin ignores the opposite transition and that partial clears spare the other bits. A long random run compares every read and the interrupt line against a bench model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PIN_COUNT = 8;
    localparam int ADDR_W    = 3;

    typedef logic [PIN_COUNT-1:0] pin_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SENSE  = 3'd0,
        SEL_ANYEDG = 3'd1,
        SEL_POL    = 3'd2,
        SEL_MASK   = 3'd3,
        SEL_RAW    = 3'd4,
        SEL_MASKED = 3'd5,
        SEL_CLEAR  = 3'd6,
        SEL_RSVD   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        pin_vec_t sense;
        pin_vec_t anyedge;
        pin_vec_t pol;
        pin_vec_t mask;
    } cfg_t;

    function automatic logic level_hit(input logic lvl, input logic pol);
        return lvl == pol;
    endfunction

    function automatic logic edge_hit(input logic anyedge, input logic pol,
                                      input logic is_out, input logic cur,
                                      input logic prev);
        logic moved;
        moved = cur ^ prev;
        if (is_out)
            return 1'b0;
        if (anyedge)
            return moved;
        return moved && (cur == pol);
    endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  logic [ADDR_W-1:0] addr,
    input  pin_vec_t wdata,
    input  pin_vec_t raw,
    output cfg_t     cfg,
    output pin_vec_t clr_vec,
    output pin_vec_t rdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (sel)
                SEL_SENSE:  cfg.sense   <= wdata;
                SEL_ANYEDG: cfg.anyedge <= wdata;
                SEL_POL:    cfg.pol     <= wdata;
                SEL_MASK:   cfg.mask    <= wdata;
                default:    ;
            endcase
        end
    end

    assign clr_vec = (we && sel == SEL_CLEAR) ? wdata : '0;

    always_comb begin
        case (sel)
            SEL_SENSE:  rdata = cfg.sense;
            SEL_ANYEDG: rdata = cfg.anyedge;
            SEL_POL:    rdata = cfg.pol;
            SEL_MASK:   rdata = cfg.mask;
            SEL_RAW:    rdata = raw;
            SEL_MASKED: rdata = raw & cfg.mask;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pin_lvl,
    input  pin_vec_t pin_dir,
    input  cfg_t     cfg,
    output pin_vec_t det
);

    pin_vec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '0;
        else
            prev_q <= pin_lvl;
    end

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
        assign det[g] = cfg.sense[g]
            ? level_hit(pin_lvl[g], cfg.pol[g])
            : edge_hit(cfg.anyedge[g], cfg.pol[g], pin_dir[g], pin_lvl[g], prev_q[g]);
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t det,
    input  pin_vec_t clr_vec,
    input  pin_vec_t mask,
    output pin_vec_t raw,
    output logic     irq
);

    always_ff @(posedge clk) begin
        if (rst)
            raw <= '0;
        else
            raw <= (raw & ~clr_vec) | det;
    end

    assign irq = |(raw & mask);

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [PIN_COUNT-1:0] bus_wdata,
    output logic [PIN_COUNT-1:0] bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_lvl,
    input  logic [PIN_COUNT-1:0] pin_dir,
    output logic                 irq
);

    cfg_t     cfg_q;
    pin_vec_t clr_vec;
    pin_vec_t det;
    pin_vec_t raw_q;

    gpio_irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .raw     (raw_q),
        .cfg     (cfg_q),
        .clr_vec (clr_vec),
        .rdata   (bus_rdata)
    );

    gpio_irq_detect u_detect (
        .clk     (clk),
        .rst     (rst),
        .pin_lvl (pin_lvl),
        .pin_dir (pin_dir),
        .cfg     (cfg_q),
        .det     (det)
    );

    gpio_irq_status u_status (
        .clk     (clk),
        .rst     (rst),
        .det     (det),
        .clr_vec (clr_vec),
        .mask    (cfg_q.mask),
        .raw     (raw_q),
        .irq     (irq)
    );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 we,
    input logic [ADDR_W-1:0]    addr,
    input logic [PIN_COUNT-1:0] wdata,
    input logic [PIN_COUNT-1:0] rdata,
    input logic [PIN_COUNT-1:0] pin_lvl,
    input logic [PIN_COUNT-1:0] pin_dir,
    input logic                 irq,
    input logic [PIN_COUNT-1:0] det,
    input logic [PIN_COUNT-1:0] raw,
    input logic [PIN_COUNT-1:0] sense,
    input logic [PIN_COUNT-1:0] pol,
    input logic [PIN_COUNT-1:0] mask
);

    logic [PIN_COUNT-1:0] clr_req;
    logic [PIN_COUNT-1:0] lvl_match;

    assign clr_req   = (we && addr == SEL_CLEAR) ? wdata : '0;
    assign lvl_match = sense & ~(pin_lvl ^ pol);

    // R2
    level_reassert_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_match != '0) |=> ((raw & $past(lvl_match)) == $past(lvl_match)));

    // R5
    out_pin_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (det & ~sense & pin_dir) == '0);

    // R6
    sticky_raw_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(raw) & ~$past(clr_req)) & ~raw) == '0));

    // R7
    detect_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (det != '0) |=> ((raw & $past(det)) == $past(det)));

    // R8
    masked_read_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == SEL_MASKED) |-> (rdata == (raw & mask)));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == SEL_MASKED && rdata == '0) |-> !irq);

endmodule

bind gpio_irq_unit gpio_irq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .pin_lvl (pin_lvl),
    .pin_dir (pin_dir),
    .irq     (irq),
    .det     (det),
    .raw     (raw_q),
    .sense   (cfg_q.sense),
    .pol     (cfg_q.pol),
    .mask    (cfg_q.mask)
);

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
module test_gpio_irq_unit;
    import gpio_irq_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_lvl = '0;
    logic [7:0] pin_dir = '0;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    gpio_irq_unit i_gpio_irq_unit (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_lvl(pin_lvl),
        .pin_dir(pin_dir), .irq(irq)
    );

    // bench model, built from the requirements
    logic [7:0] m_sense, m_any, m_pol, m_mask, m_raw, m_prev;

    function automatic logic [7:0] m_detect(input logic [7:0] lvl, input logic [7:0] dir);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) begin
            if (m_sense[i])
                d[i] = (lvl[i] == m_pol[i]);
            else if (dir[i] || lvl[i] == m_prev[i])
                d[i] = 1'b0;
            else
                d[i] = m_any[i] ? 1'b1 : (lvl[i] == m_pol[i]);
        end
        return d;
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_sense;
            3'd1: return m_any;
            3'd2: return m_pol;
            3'd3: return m_mask;
            3'd4: return m_raw;
            3'd5: return m_raw & m_mask;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sense = 0; m_any = 0; m_pol = 0; m_mask = 0; m_raw = 0; m_prev = 0;
        end else begin
            logic [7:0] d, c;
            d = m_detect(pin_lvl, pin_dir);
            c = (bus_we && bus_addr == 3'd6) ? bus_wdata : 8'h00;
            m_raw = (m_raw & ~c) | d;
            if (bus_we) begin
                case (bus_addr)
                    3'd0: m_sense = bus_wdata;
                    3'd1: m_any   = bus_wdata;
                    3'd2: m_pol   = bus_wdata;
                    3'd3: m_mask  = bus_wdata;
                    default: ;
                endcase
            end
            m_prev = pin_lvl;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic setpins(input logic [7:0] v);
        @(negedge clk);
        pin_lvl = v;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) rd("R1 reset read", 3'(a), 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);

        // R9 readback and ignored writes
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'hFF);
        wr(3'd7, 8'h5A);
        rd("R9 raw not writable", 3'd4, 8'h00);
        rd("R9 mask readback", 3'd3, 8'hFF);
        rd("R9 reserved reads 0", 3'd7, 8'h00);

        // R4 single-edge polarity, R10 latency
        wr(3'd2, 8'h01);
        rd("R9 pol readback", 3'd2, 8'h01);
        setpins(8'h01);
        rd("R4 R10 rise detected", 3'd4, 8'h01);
        check("R8 irq on rise", {7'b0, irq}, 8'h01);
        wr(3'd6, 8'hFF);
        rd("R6 clear all", 3'd4, 8'h00);
        setpins(8'h00);
        rd("R4 fall ignored when pol=1", 3'd4, 8'h00);
        setpins(8'h02);
        rd("R4 rise ignored when pol=0", 3'd4, 8'h00);
        setpins(8'h00);
        rd("R4 fall detected", 3'd4, 8'h02);
        wr(3'd6, 8'h01);
        rd("R6 partial clear spares bit", 3'd4, 8'h02);
        rd("R6 still sticky", 3'd4, 8'h02);
        wr(3'd6, 8'h02);
        rd("R6 clear bit1", 3'd4, 8'h00);

        // R3 any edge
        wr(3'd1, 8'h04);
        setpins(8'h04);
        rd("R3 rise with any-edge", 3'd4, 8'h04);
        wr(3'd6, 8'hFF);
        setpins(8'h00);
        rd("R3 fall with any-edge", 3'd4, 8'h04);
        wr(3'd6, 8'hFF);

        // R5 output pins ignore edges
        wr(3'd1, 8'hFF);
        @(negedge clk);
        pin_dir = 8'hF0; pin_lvl = 8'hFF;
        rd("R5 only input pins latch", 3'd4, 8'h0F);
        wr(3'd6, 8'hFF);
        @(negedge clk);
        pin_dir = 8'h00;
        rd("R5 cleared", 3'd4, 8'h00);

        // R2 level mode, re-set after clear
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h10);
        rd("R2 no match no set", 3'd4, 8'h00);
        setpins(8'hEF);
        rd("R2 low level sets", 3'd4, 8'h10);
        wr(3'd6, 8'h10);
        rd("R2 level reasserts after clear", 3'd4, 8'h10);
        setpins(8'hFF);
        wr(3'd6, 8'hFF);
        rd("R2 gone after level ends", 3'd4, 8'h00);

        // R7 clear and detect in the same cycle
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h01);
        setpins(8'hFE);
        rd("R3 fall pin0", 3'd4, 8'h01);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h01; pin_lvl = 8'hFF;
        @(negedge clk);
        bus_we = 1'b0;
        rd("R7 detect beats clear", 3'd4, 8'h01);

        // R8 masking
        rd("R8 masked read", 3'd5, 8'h01);
        check("R8 irq high", {7'b0, irq}, 8'h01);
        wr(3'd3, 8'h00);
        rd("R8 masked read with mask 0", 3'd5, 8'h00);
        check("R8 irq low when masked", {7'b0, irq}, 8'h00);
        rd("R8 raw unaffected by mask", 3'd4, 8'h01);
        wr(3'd3, 8'hFF);
        wr(3'd6, 8'hFF);

        // random phase against model
        for (int i = 0; i < 3000; i++) begin
            int r;
            @(negedge clk);
            check("R8 irq random", {7'b0, irq}, {7'b0, |(m_raw & m_mask)});
            r = int'($urandom % 10);
            if (r < 3) begin
                bus_we = 1'b1; bus_addr = 3'($urandom); bus_wdata = 8'($urandom);
            end else begin
                bus_we = 1'b0; bus_addr = 3'($urandom);
                #1;
                check("R9 R10 random read", bus_rdata, m_read(bus_addr));
            end
            if ($urandom % 3 == 0) pin_lvl = pin_lvl ^ 8'(1 << ($urandom % 8));
            if ($urandom % 20 == 0) pin_dir = 8'($urandom);
        end
        @(negedge clk);
        bus_we = 1'b0;

        done = 1;
        summary();
    end

endmodule